// File: doc/BRIEF.md
# Dual-register configuration output selector

This block drives a 5-bit configuration word and one auxiliary bit. It replaces jumpers or switch banks on a board-level control path. The word can come from one of three places: two 6-bit stored settings, or a 5-bit external input bus. Two select pins pick the place. A 2-bit override mode can take priority over the pins and force a fixed place.

The auxiliary bit is the top bit (bit 5) of a stored setting. It is passed straight through when a stored setting drives the word. When the external bus drives the word, the auxiliary bit holds the value it last showed.

That hold is built as a clocked register with an enable. While the path is transparent the register reloads on every cycle, and the output is taken from the live input. While the path is held, the output comes from the register.

Top module: `cfg_source_select`

## Requirements
- R1: With override mode 2'b00 (pin control), `sel0`=0 and `sel1`=1, `cfg_out` equals `reg0_val[4:0]` and `aux_out` equals `reg0_val[5]` in the same cycle.
- R2: With override mode 2'b00, `sel0`=0 and `sel1`=0, `cfg_out` equals `reg1_val[4:0]` and `aux_out` equals `reg1_val[5]` in the same cycle.
- R3: With override mode 2'b00 and `sel0`=1, `cfg_out` equals `ext_in` in the same cycle, whatever the value of `sel1`.
- R4: The auxiliary path is held whenever `sel0`=1 under pin control, or the override mode is 2'b11. While held, `aux_out` keeps the bit it showed in the last cycle before the hold began. Changes to either stored setting during the hold have no effect on it.
- R5: Override mode 2'b01 forces the register 0 source and mode 2'b10 forces the register 1 source. In both cases `aux_out` passes the matching bit 5 through, and the select pins have no effect.
- R6: Override mode 2'b11 forces `cfg_out` to `ext_in` and keeps the auxiliary path held, whatever the select pins are.
- R7: After reset the held auxiliary value is 0. It stays 0 until the first transparent cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the auxiliary hold register |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg0_val | input | 6 | Stored setting 0; bit 5 feeds the auxiliary bit |
| reg1_val | input | 6 | Stored setting 1; bit 5 feeds the auxiliary bit |
| ext_in | input | 5 | External configuration bus |
| sel0 | input | 1 | Pin select: 1 picks the external bus and holds the auxiliary bit |
| sel1 | input | 1 | Pin select between setting 0 (1) and setting 1 (0) |
| ovr_mode | input | 2 | 00 pins, 01 force setting 0, 10 force setting 1, 11 force external bus |
| cfg_out | output | 5 | Selected configuration word |
| aux_out | output | 1 | Auxiliary bit, transparent or held |

## Verification
The word path has no storage, so a wrong source decode shows on `cfg_out` in the same cycle the inputs change. The only state is the held auxiliary bit.

A hold register that loads while it should be closed shows up as `aux_out` following a changed bit 5 during a hold. A register that fails to load shows up as a stale value on the first held cycle after a transparent one. A bad reset value shows up on `aux_out` before the first transparent cycle.

The bench therefore changes bit 5 of both settings while the path is held, and checks every cycle.

// File: rtl/cfg_source_select_pkg.sv
package cfg_source_select_pkg;

  typedef enum logic [1:0] {
    MODE_PINS  = 2'b00,
    MODE_REG0  = 2'b01,
    MODE_REG1  = 2'b10,
    MODE_EXT   = 2'b11
  } ovr_mode_e;

  typedef enum logic [1:0] {
    SRC_REG0 = 2'd0,
    SRC_REG1 = 2'd1,
    SRC_EXT  = 2'd2
  } word_src_e;

endpackage

// File: rtl/cfg_rst_sync.sv
module cfg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/cfg_src_decode.sv
module cfg_src_decode
  import cfg_source_select_pkg::*;
(
  input  ovr_mode_e mode,
  input  logic      sel0,
  input  logic      sel1,
  output word_src_e word_src,
  output logic      aux_pick_reg1,
  output logic      aux_pass
);

  always_comb begin
    word_src      = SRC_EXT;
    aux_pick_reg1 = ~sel1;
    aux_pass      = 1'b0;
    unique case (mode)
      MODE_PINS: begin
        aux_pass = ~sel0;
        if (sel0)      word_src = SRC_EXT;
        else if (sel1) word_src = SRC_REG0;
        else           word_src = SRC_REG1;
      end
      MODE_REG0: begin
        word_src      = SRC_REG0;
        aux_pick_reg1 = 1'b0;
        aux_pass      = 1'b1;
      end
      MODE_REG1: begin
        word_src      = SRC_REG1;
        aux_pick_reg1 = 1'b1;
        aux_pass      = 1'b1;
      end
      default: begin
        word_src = SRC_EXT;
        aux_pass = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/cfg_word_mux.sv
module cfg_word_mux
  import cfg_source_select_pkg::*;
#(
  parameter int CFG_W = 5
) (
  input  word_src_e        word_src,
  input  logic [CFG_W-1:0] reg0_word,
  input  logic [CFG_W-1:0] reg1_word,
  input  logic [CFG_W-1:0] ext_word,
  output logic [CFG_W-1:0] word_out
);

  for (genvar b = 0; b < CFG_W; b++) begin : g_bit
    always_comb begin
      unique case (word_src)
        SRC_REG0: word_out[b] = reg0_word[b];
        SRC_REG1: word_out[b] = reg1_word[b];
        default:  word_out[b] = ext_word[b];
      endcase
    end
  end

endmodule

// File: rtl/cfg_aux_hold.sv
module cfg_aux_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic pass,
  input  logic aux_d,
  output logic aux_q_out
);

  logic held_q;
  logic held_d;
  logic held_en;

  always_comb begin
    held_en = pass;
    held_d  = aux_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       held_q <= 1'b0;
    else if (held_en) held_q <= held_d;
  end

  assign aux_q_out = pass ? aux_d : held_q;

endmodule

// File: rtl/cfg_source_select.sv
module cfg_source_select
  import cfg_source_select_pkg::*;
#(
  parameter int CFG_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CFG_W:0]   reg0_val,
  input  logic [CFG_W:0]   reg1_val,
  input  logic [CFG_W-1:0] ext_in,
  input  logic             sel0,
  input  logic             sel1,
  input  logic [1:0]       ovr_mode,
  output logic [CFG_W-1:0] cfg_out,
  output logic             aux_out
);

  localparam int AUX_BIT = CFG_W;

  logic      rst_n_sync;
  ovr_mode_e mode;
  word_src_e word_src;
  logic      aux_pick_reg1;
  logic      aux_pass;
  logic      aux_d;

  assign mode  = ovr_mode_e'(ovr_mode);
  assign aux_d = aux_pick_reg1 ? reg1_val[AUX_BIT] : reg0_val[AUX_BIT];

  cfg_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  cfg_src_decode u_decode (
    .mode          (mode),
    .sel0          (sel0),
    .sel1          (sel1),
    .word_src      (word_src),
    .aux_pick_reg1 (aux_pick_reg1),
    .aux_pass      (aux_pass)
  );

  cfg_word_mux #(.CFG_W(CFG_W)) u_mux (
    .word_src  (word_src),
    .reg0_word (reg0_val[CFG_W-1:0]),
    .reg1_word (reg1_val[CFG_W-1:0]),
    .ext_word  (ext_in),
    .word_out  (cfg_out)
  );

  cfg_aux_hold u_aux (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .pass      (aux_pass),
    .aux_d     (aux_d),
    .aux_q_out (aux_out)
  );

endmodule

// File: rtl/cfg_source_select_chk.sv
module cfg_source_select_chk #(
  parameter int CFG_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CFG_W:0]   reg0_val,
  input logic [CFG_W:0]   reg1_val,
  input logic [CFG_W-1:0] ext_in,
  input logic             sel0,
  input logic             sel1,
  input logic [1:0]       ovr_mode,
  input logic [CFG_W-1:0] cfg_out,
  input logic             aux_out
);

  logic armed;
  logic held;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  assign held = (ovr_mode == 2'b11) || (ovr_mode == 2'b00 && sel0);

  assert_pin_reg0_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_mode == 2'b00 && !sel0 && sel1) |->
      (cfg_out == reg0_val[CFG_W-1:0] && aux_out == reg0_val[CFG_W]));

  assert_pin_reg1_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_mode == 2'b00 && !sel0 && !sel1) |->
      (cfg_out == reg1_val[CFG_W-1:0] && aux_out == reg1_val[CFG_W]));

  assert_pin_ext_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_mode == 2'b00 && sel0) |-> (cfg_out == ext_in));

  assert_hold_keeps_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && held) |-> (aux_out == $past(aux_out)));

  assert_force_reg0_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_mode == 2'b01) |->
      (cfg_out == reg0_val[CFG_W-1:0] && aux_out == reg0_val[CFG_W]));

  assert_force_reg1_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_mode == 2'b10) |->
      (cfg_out == reg1_val[CFG_W-1:0] && aux_out == reg1_val[CFG_W]));

  assert_force_ext_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_mode == 2'b11) |-> (cfg_out == ext_in));

  assert_reset_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && held) |-> (aux_out == 1'b0));

endmodule

bind cfg_source_select cfg_source_select_chk #(.CFG_W(CFG_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n_sync),
  .reg0_val (reg0_val),
  .reg1_val (reg1_val),
  .ext_in   (ext_in),
  .sel0     (sel0),
  .sel1     (sel1),
  .ovr_mode (ovr_mode),
  .cfg_out  (cfg_out),
  .aux_out  (aux_out)
);

// File: tb/cfg_source_select_bench.sv
module cfg_source_select_bench;

  localparam int CLK_PERIOD = 10;
  localparam int W = 5;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [W:0]   reg0_val;
  logic [W:0]   reg1_val;
  logic [W-1:0] ext_in;
  logic         sel0;
  logic         sel1;
  logic [1:0]   ovr_mode;
  logic [W-1:0] cfg_out;
  logic         aux_out;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;
  bit model_en = 1'b0;
  logic model_lat = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_source_select #(.CFG_W(W)) u_cfg_source_select (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg0_val (reg0_val),
    .reg1_val (reg1_val),
    .ext_in   (ext_in),
    .sel0     (sel0),
    .sel1     (sel1),
    .ovr_mode (ovr_mode),
    .cfg_out  (cfg_out),
    .aux_out  (aux_out)
  );

  function automatic logic exp_pass(input logic [1:0] m, input logic s0);
    return (m == 2'b01) || (m == 2'b10) || (m == 2'b00 && !s0);
  endfunction

  function automatic logic exp_bit(input logic [1:0] m, input logic s1,
                                   input logic [W:0] r0, input logic [W:0] r1);
    if (m == 2'b01) return r0[W];
    if (m == 2'b10) return r1[W];
    return s1 ? r0[W] : r1[W];
  endfunction

  function automatic logic [W-1:0] exp_word(input logic [1:0] m, input logic s0,
      input logic s1, input logic [W:0] r0, input logic [W:0] r1,
      input logic [W-1:0] e);
    case (m)
      2'b01:   return r0[W-1:0];
      2'b10:   return r1[W-1:0];
      2'b11:   return e;
      default: return s0 ? e : (s1 ? r0[W-1:0] : r1[W-1:0]);
    endcase
  endfunction

  always @(posedge clk) begin
    if (model_en && exp_pass(ovr_mode, sel0))
      model_lat <= exp_bit(ovr_mode, sel1, reg0_val, reg1_val);
  end

  function automatic string req_of(input logic [1:0] m, input logic s0, input logic s1);
    if (m == 2'b01 || m == 2'b10) return "R5";
    if (m == 2'b11) return "R6";
    if (s0) return "R3/R4";
    return s1 ? "R1" : "R2";
  endfunction

  task automatic check(input string req);
    logic [W-1:0] ew;
    logic         ea;
    ew = exp_word(ovr_mode, sel0, sel1, reg0_val, reg1_val, ext_in);
    ea = exp_pass(ovr_mode, sel0) ? exp_bit(ovr_mode, sel1, reg0_val, reg1_val)
                                  : model_lat;
    n_checks++;
    if (cfg_out !== ew || aux_out !== ea) begin
      n_fail++;
      $display("FAIL %s: cfg_out=%b aux_out=%b expected cfg_out=%b aux_out=%b",
               req, cfg_out, aux_out, ew, ea);
    end
  endtask

  task automatic apply(input logic [1:0] m, input logic s0, input logic s1,
                       input logic [W:0] r0, input logic [W:0] r1,
                       input logic [W-1:0] e);
    @(negedge clk);
    ovr_mode = m; sel0 = s0; sel1 = s1;
    reg0_val = r0; reg1_val = r1; ext_in = e;
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: run did not end, actual=hung expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5EED_C0DE));
    rst_n = 1'b0;
    ovr_mode = 2'b00; sel0 = 1'b1; sel1 = 1'b1;
    reg0_val = 6'h3F; reg1_val = 6'h3F; ext_in = 5'h15;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    model_en = 1'b1;

    // R7: held value cleared by reset although both settings carry bit 5 = 1
    apply(2'b00, 1'b1, 1'b1, 6'h3F, 6'h3F, 5'h15); check("R7");
    apply(2'b00, 1'b1, 1'b0, 6'h3F, 6'h3F, 5'h0A); check("R7");

    // R1, R2 transparent pin selections
    apply(2'b00, 1'b0, 1'b1, 6'h2A, 6'h15, 5'h1F); check("R1");
    apply(2'b00, 1'b0, 1'b0, 6'h2A, 6'h15, 5'h1F); check("R2");
    apply(2'b00, 1'b0, 1'b0, 6'h00, 6'h3C, 5'h00); check("R2");

    // R3 with either sel1
    apply(2'b00, 1'b1, 1'b0, 6'h00, 6'h3C, 5'h13); check("R3");
    apply(2'b00, 1'b1, 1'b1, 6'h00, 6'h3C, 5'h0C); check("R3");

    // R4: capture 1 from setting 0, then clear bit 5 of both during hold
    apply(2'b00, 1'b0, 1'b1, 6'h20, 6'h00, 5'h00); check("R1");
    apply(2'b00, 1'b1, 1'b1, 6'h00, 6'h00, 5'h07); check("R4");
    apply(2'b00, 1'b1, 1'b0, 6'h00, 6'h00, 5'h08); check("R4");
    apply(2'b00, 1'b1, 1'b0, 6'h1F, 6'h1F, 5'h09); check("R4");
    // capture 0 from setting 1, then set bit 5 of both during hold
    apply(2'b00, 1'b0, 1'b0, 6'h3F, 6'h00, 5'h00); check("R2");
    apply(2'b00, 1'b1, 1'b0, 6'h3F, 6'h3F, 5'h11); check("R4");

    // R5 forced sources ignore the pins
    apply(2'b01, 1'b1, 1'b0, 6'h35, 6'h0A, 5'h1E); check("R5");
    apply(2'b10, 1'b1, 1'b1, 6'h35, 6'h0A, 5'h1E); check("R5");
    apply(2'b10, 1'b0, 1'b1, 6'h35, 6'h2B, 5'h1E); check("R5");

    // R6 forced external bus holds the bit captured just above (1)
    apply(2'b11, 1'b0, 1'b1, 6'h00, 6'h00, 5'h05); check("R6");
    apply(2'b11, 1'b0, 1'b0, 6'h00, 6'h00, 5'h1A); check("R6");

    // Random mix
    for (int i = 0; i < 600; i++) begin
      logic [1:0] m;
      m = ($urandom_range(0, 1) == 0) ? 2'b00 : 2'($urandom_range(0, 3));
      apply(m, 1'($urandom), 1'($urandom), 6'($urandom), 6'($urandom), 5'($urandom));
      check(req_of(ovr_mode, sel0, sel1));
    end

    finish_run();
  end

endmodule